// File: doc/BRIEF.md
# Phase Detector with Lock Monitor

This block compares two single-cycle edge strobes, one from the reference divider and one from the divided oscillator, on a fast sample clock. The time between them becomes a pulse on a tri-state main pump. The pump sources current when the divided edge comes first, which means the oscillator runs fast. It sinks current when the reference edge comes first. It floats when no comparison is in progress. A second, sub pump copies the main pump. It can be held floating, run all the time, or run only while the loop is out of lock, so that the loop filter is sped up during acquisition.

The comparison logic also measures each phase error in sample cycles and checks it against a selectable window. Any error wider than the window drives an active-low unlock flag. The flag stays low for a whole number of millisecond ticks after the last violation. Four dead-zone modes change the pulses. Two overlap modes close every comparison with a short burst on both pump directions. Two gap modes mask the start of every pulse, so that tiny errors cause no pump action. A deadlock-clear control pulls every pump low. An inhibit control floats every pump and clears the comparator.

Top module: `pfd_lock_det`

## Requirements
- R1: A divided edge that comes before the reference edge by L cycles drives main_up with main_oe high for L cycles. A reference edge that comes first drives main_dn instead. With no comparison in progress and no overlap burst, main_oe is low.
- R2: The unlock code sets the window W. Code 00 disables detection, so unlock_oe is 0 and unlock_n is 1. Codes 01 and 10 give W = WIN_NARROW, which is 4 by default. Code 11 gives W = WIN_WIDE, which is 8 by default. An error of more than W cycles drives unlock_n low with unlock_oe at 1. An error of W cycles or fewer does not.
- R3: After the last cycle of violation, unlock_n stays low until STRETCH_TICKS ms_tick pulses (2 by default) have been counted. It goes high in the cycle after the last of those ticks. Without ticks it stays low.
- R4: Sub code 00 or 01 keeps sub_oe at 0. Sub code 11 makes sub_up, sub_dn and sub_oe follow the main pump.
- R5: Sub code 10 lets the sub pump follow the main pump only while unlock detection reports unlocked. Once the error is back inside the window and the hold time has ended, sub_oe stays at 0 even while main pulses continue.
- R6: With deadlock-clear set and inhibit clear, both pumps have oe=1, dn=1 and up=0 in every cycle, whatever the sub code. Clearing the bit brings normal operation back in the same cycle.
- R7: Dead-zone code 00 ends each comparison with OVL_WIDE cycles (2 by default) and code 01 with OVL_NARROW cycles (1 by default) in which up and dn are both high. This includes comparisons whose two edges arrive in the same cycle.
- R8: Dead-zone code 10 masks the first DZ_NARROW cycles (1 by default) of each pump pulse, and code 11 masks the first DZ_WIDE cycles (3 by default). A pulse of L cycles gives max(0, L - mask) cycles of output.
- R9: With inhibit set, all pump oe outputs are 0 and no unlock is detected. Inhibit takes priority over deadlock-clear.
- R10: During reset both pumps float and unlock_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle strobe from the reference divider |
| div_edge | input | 1 | One-cycle strobe from the oscillator divider |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| ulw_code | input | 2 | Unlock window select |
| dz_code | input | 2 | Dead-zone mode select |
| sub_code | input | 2 | Sub pump control |
| dlc_force | input | 1 | Deadlock clear: pull all pumps low |
| inhibit | input | 1 | Float all pumps and clear the comparator |
| main_up | output | 1 | Main pump source request |
| main_dn | output | 1 | Main pump sink request |
| main_oe | output | 1 | Main pump drive enable (0 = high impedance) |
| sub_up | output | 1 | Sub pump source request |
| sub_dn | output | 1 | Sub pump sink request |
| sub_oe | output | 1 | Sub pump drive enable (0 = high impedance) |
| unlock_n | output | 1 | Unlock flag, active low |
| unlock_oe | output | 1 | Unlock flag drive enable (0 = open) |

## Verification
Each check counts how many cycles each pump output is on per comparison. A pulse counter that is off by one therefore shows up as one cycle too many or too few on main_up or main_dn within the same comparison. A stuck or mis-reloaded hold counter shows up on unlock_n only at the millisecond tick that should have released it. For that reason the release is checked on each tick separately. The sub pump in lock-gated mode exposes the unlock state directly: a wrong unlocked bit makes sub_oe appear in the first violating cycle, or makes it vanish there.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic [1:0] {
    DZ_OVL_WIDE   = 2'b00,
    DZ_OVL_NARROW = 2'b01,
    DZ_GAP_NARROW = 2'b10,
    DZ_GAP_WIDE   = 2'b11
  } dz_mode_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles masked at the start of each pump pulse
  function automatic int gap_len(input dz_mode_e m, input int narrow, input int wide);
    case (m)
      DZ_GAP_NARROW: return narrow;
      DZ_GAP_WIDE:   return wide;
      default:       return 0;
    endcase
  endfunction

  // cycles of simultaneous up/dn after each comparison
  function automatic int ovl_len(input dz_mode_e m, input int narrow, input int wide);
    case (m)
      DZ_OVL_WIDE:   return wide;
      DZ_OVL_NARROW: return narrow;
      default:       return 0;
    endcase
  endfunction

  // tolerated phase error in cycles; 00 means detection off
  function automatic int win_len(input logic [1:0] code, input int narrow, input int wide);
    case (code)
      2'b00:   return 0;
      2'b11:   return wide;
      default: return narrow;
    endcase
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ref_edge,
  input  logic             div_edge,
  output logic             up_st,
  output logic             dn_st,
  output logic [CNT_W-1:0] cnt,
  output logic             close_evt
);

  logic raw_up, raw_dn, both;
  logic up_d, dn_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    raw_up = up_st | div_edge;
    raw_dn = dn_st | ref_edge;
    both   = raw_up & raw_dn;
    up_d   = raw_up & ~both;
    dn_d   = raw_dn & ~both;
    if (up_d | dn_d) begin
      if (up_st | dn_st)
        cnt_d = (cnt == {CNT_W{1'b1}}) ? cnt : cnt + CNT_W'(1);
      else
        cnt_d = CNT_W'(1);
    end else begin
      cnt_d = '0;
    end
    close_evt = both & ~clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      up_st <= 1'b0;
      dn_st <= 1'b0;
      cnt   <= '0;
    end else begin
      up_st <= up_d;
      dn_st <= dn_d;
      cnt   <= cnt_d;
    end
  end

endmodule

// File: rtl/unlock_detect.sv
module unlock_detect
  import pfd_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int WIN_NARROW    = 4,
  parameter int WIN_WIDE      = 8,
  parameter int STRETCH_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       ulw_code,
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic             ms_tick,
  output logic             viol,
  output logic             unlocked,
  output logic             unlock_n,
  output logic             unlock_oe
);

  localparam int SW = $clog2(STRETCH_TICKS + 1);

  logic             en;
  logic [CNT_W-1:0] win_w;
  logic [SW-1:0]    hold_q;

  always_comb begin
    en        = (ulw_code != 2'b00);
    win_w     = CNT_W'(win_len(ulw_code, WIN_NARROW, WIN_WIDE));
    viol      = en & active & (cnt > win_w);
    unlocked  = en & (viol | (hold_q != '0));
    unlock_oe = en;
    unlock_n  = ~unlocked;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en)
      hold_q <= '0;
    else if (viol)
      hold_q <= SW'(STRETCH_TICKS);
    else if (ms_tick && hold_q != '0)
      hold_q <= hold_q - SW'(1);
  end

endmodule

// File: rtl/pump_shaper.sv
module pump_shaper
  import pfd_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int DZ_NARROW  = 1,
  parameter int DZ_WIDE    = 3,
  parameter int OVL_NARROW = 1,
  parameter int OVL_WIDE   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       dz_code,
  input  logic             up_st,
  input  logic             dn_st,
  input  logic [CNT_W-1:0] cnt,
  input  logic             close_evt,
  output logic             up_g,
  output logic             dn_g
);

  localparam int OVL_MAX = max2(OVL_WIDE, OVL_NARROW);
  localparam int OW      = $clog2(OVL_MAX + 1);

  dz_mode_e         mode;
  logic [CNT_W-1:0] gap_w;
  logic [OW-1:0]    ovl_q;
  logic             pass, ovl_on;

  always_comb begin
    mode   = dz_mode_e'(dz_code);
    gap_w  = CNT_W'(gap_len(mode, DZ_NARROW, DZ_WIDE));
    pass   = (cnt > gap_w);
    ovl_on = (ovl_q != '0);
    up_g   = (up_st & pass) | ovl_on;
    dn_g   = (dn_st & pass) | ovl_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      ovl_q <= '0;
    else if (close_evt)
      ovl_q <= OW'(ovl_len(mode, OVL_NARROW, OVL_WIDE));
    else if (ovl_on)
      ovl_q <= ovl_q - OW'(1);
  end

endmodule

// File: rtl/pump_drive.sv
module pump_drive (
  input  logic up_g,
  input  logic dn_g,
  input  logic run,
  input  logic dlc_force,
  input  logic inhibit,
  output logic up,
  output logic dn,
  output logic oe
);

  always_comb begin
    if (inhibit) begin
      up = 1'b0; dn = 1'b0; oe = 1'b0;
    end else if (dlc_force) begin
      up = 1'b0; dn = 1'b1; oe = 1'b1;
    end else if (run) begin
      up = up_g; dn = dn_g; oe = up_g | dn_g;
    end else begin
      up = 1'b0; dn = 1'b0; oe = 1'b0;
    end
  end

endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int CNT_W         = 8,
  parameter int WIN_NARROW    = 4,
  parameter int WIN_WIDE      = 8,
  parameter int DZ_NARROW     = 1,
  parameter int DZ_WIDE       = 3,
  parameter int OVL_NARROW    = 1,
  parameter int OVL_WIDE      = 2,
  parameter int STRETCH_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_edge,
  input  logic       div_edge,
  input  logic       ms_tick,
  input  logic [1:0] ulw_code,
  input  logic [1:0] dz_code,
  input  logic [1:0] sub_code,
  input  logic       dlc_force,
  input  logic       inhibit,
  output logic       main_up,
  output logic       main_dn,
  output logic       main_oe,
  output logic       sub_up,
  output logic       sub_dn,
  output logic       sub_oe,
  output logic       unlock_n,
  output logic       unlock_oe
);

  localparam int NPUMP = 2;

  logic             up_st, dn_st, close_w;
  logic [CNT_W-1:0] cnt_w;
  logic             viol_w, unlocked_w;
  logic             up_g, dn_g;
  logic [NPUMP-1:0] run_v, up_v, dn_v, oe_v;

  pfd_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(inhibit),
    .ref_edge(ref_edge), .div_edge(div_edge),
    .up_st(up_st), .dn_st(dn_st), .cnt(cnt_w), .close_evt(close_w)
  );

  unlock_detect #(
    .CNT_W(CNT_W), .WIN_NARROW(WIN_NARROW), .WIN_WIDE(WIN_WIDE),
    .STRETCH_TICKS(STRETCH_TICKS)
  ) u_unlock (
    .clk(clk), .rst_n(rst_n), .ulw_code(ulw_code),
    .active(up_st | dn_st), .cnt(cnt_w), .ms_tick(ms_tick),
    .viol(viol_w), .unlocked(unlocked_w),
    .unlock_n(unlock_n), .unlock_oe(unlock_oe)
  );

  pump_shaper #(
    .CNT_W(CNT_W), .DZ_NARROW(DZ_NARROW), .DZ_WIDE(DZ_WIDE),
    .OVL_NARROW(OVL_NARROW), .OVL_WIDE(OVL_WIDE)
  ) u_shape (
    .clk(clk), .rst_n(rst_n), .clr(inhibit), .dz_code(dz_code),
    .up_st(up_st), .dn_st(dn_st), .cnt(cnt_w), .close_evt(close_w),
    .up_g(up_g), .dn_g(dn_g)
  );

  // pump 0 = main (always runs), pump 1 = sub (gated by code and lock state)
  assign run_v[0] = 1'b1;
  assign run_v[1] = sub_code[1] & (sub_code[0] | unlocked_w);

  for (genvar g = 0; g < NPUMP; g++) begin : g_pump
    pump_drive u_drv (
      .up_g(up_g), .dn_g(dn_g), .run(run_v[g]),
      .dlc_force(dlc_force), .inhibit(inhibit),
      .up(up_v[g]), .dn(dn_v[g]), .oe(oe_v[g])
    );
  end

  assign main_up = up_v[0];
  assign main_dn = dn_v[0];
  assign main_oe = oe_v[0];
  assign sub_up  = up_v[1];
  assign sub_dn  = dn_v[1];
  assign sub_oe  = oe_v[1];

endmodule

// File: rtl/pfd_lock_det_chk.sv
module pfd_lock_det_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inhibit,
  input logic             dlc_force,
  input logic [1:0]       ulw_code,
  input logic [1:0]       dz_code,
  input logic [1:0]       sub_code,
  input logic             main_up,
  input logic             main_dn,
  input logic             main_oe,
  input logic             sub_up,
  input logic             sub_dn,
  input logic             sub_oe,
  input logic             unlock_n,
  input logic             unlock_oe,
  input logic             viol,
  input logic [CNT_W-1:0] pulse_cnt
);

  p_inhibit_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> (!main_oe && !sub_oe));

  p_dlc_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit && dlc_force) |->
      (main_oe && main_dn && !main_up && sub_oe && sub_dn && !sub_up));

  p_sub_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!inhibit && !dlc_force && !sub_code[1]) |-> !sub_oe);

  p_flag_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ulw_code == 2'b00) |-> (unlock_n && !unlock_oe));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && ulw_code != 2'b00) |=> (!unlock_n || ulw_code == 2'b00));

  p_sub_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_code == 2'b10 && !inhibit && !dlc_force && ulw_code != 2'b00 && unlock_n)
      |-> !sub_oe);

  p_gap_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dz_code[1] && !inhibit && !dlc_force && pulse_cnt == CNT_W'(1)) |-> !main_oe);

endmodule

bind pfd_lock_det pfd_lock_det_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .dlc_force(dlc_force),
  .ulw_code(ulw_code), .dz_code(dz_code), .sub_code(sub_code),
  .main_up(main_up), .main_dn(main_dn), .main_oe(main_oe),
  .sub_up(sub_up), .sub_dn(sub_dn), .sub_oe(sub_oe),
  .unlock_n(unlock_n), .unlock_oe(unlock_oe),
  .viol(viol_w), .pulse_cnt(cnt_w)
);

// File: tb/pfd_lock_det_tb.sv
module pfd_lock_det_tb;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_e = 1'b0, div_e = 1'b0, ms = 1'b0;
  logic [1:0] ulw = 2'b01, dz = 2'b10, sub = 2'b00;
  logic dlc = 1'b0, inh = 1'b0;
  logic main_up, main_dn, main_oe, sub_up, sub_dn, sub_oe, unlock_n, unlock_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  pfd_lock_det u_dut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_e), .div_edge(div_e),
    .ms_tick(ms), .ulw_code(ulw), .dz_code(dz), .sub_code(sub),
    .dlc_force(dlc), .inhibit(inh),
    .main_up(main_up), .main_dn(main_dn), .main_oe(main_oe),
    .sub_up(sub_up), .sub_dn(sub_dn), .sub_oe(sub_oe),
    .unlock_n(unlock_n), .unlock_oe(unlock_oe)
  );

  typedef struct packed {
    logic [1:0] ulw;
    logic [1:0] dz;
    logic [1:0] sub;
    logic       dlc;
    logic       inh;
    logic       lead;   // 1: divided edge first
    logic [3:0] len;
    logic [3:0] e_up;
    logic [3:0] e_dn;
    logic [3:0] e_oe;
    logic [3:0] e_sub;
    logic       e_unl;
  } vec_t;

  // defaults: windows 4/8, masks 1/3, overlaps 1 (code 01) / 2 (code 00)
  localparam vec_t VECS [15] = '{
    '{2'b01, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 4'd3, 4'd2, 4'd0, 4'd2, 4'd0, 1'b0},
    '{2'b01, 2'b10, 2'b11, 1'b0, 1'b0, 1'b0, 4'd3, 4'd0, 4'd2, 4'd2, 4'd2, 1'b0},
    '{2'b01, 2'b11, 2'b11, 1'b0, 1'b0, 1'b1, 4'd3, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0},
    '{2'b01, 2'b11, 2'b00, 1'b0, 1'b0, 1'b1, 4'd6, 4'd3, 4'd0, 4'd3, 4'd0, 1'b1},
    '{2'b11, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 4'd6, 4'd5, 4'd0, 4'd5, 4'd0, 1'b0},
    '{2'b11, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 4'd9, 4'd0, 4'd8, 4'd8, 4'd0, 1'b1},
    '{2'b10, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 4'd5, 4'd4, 4'd0, 4'd4, 4'd0, 1'b1},
    '{2'b10, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 4'd4, 4'd3, 4'd0, 4'd3, 4'd0, 1'b0},
    '{2'b00, 2'b10, 2'b00, 1'b0, 1'b0, 1'b1, 4'd9, 4'd8, 4'd0, 4'd8, 4'd0, 1'b0},
    '{2'b01, 2'b00, 2'b11, 1'b0, 1'b0, 1'b1, 4'd2, 4'd4, 4'd2, 4'd4, 4'd4, 1'b0},
    '{2'b01, 2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 4'd0, 4'd1, 4'd1, 4'd1, 4'd0, 1'b0},
    '{2'b01, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 4'd0, 4'd2, 4'd2, 4'd2, 4'd0, 1'b0},
    '{2'b01, 2'b10, 2'b00, 1'b1, 1'b0, 1'b1, 4'd2, 4'd0, 4'd8, 4'd8, 4'd8, 1'b0},
    '{2'b01, 2'b10, 2'b11, 1'b1, 1'b1, 1'b1, 4'd6, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0},
    '{2'b01, 2'b00, 2'b11, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 4'd6, 4'd6, 4'd6, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // one comparison of len cycles, sampled for len+6 cycles
  task automatic do_pulse(input bit lead, input int len,
                          output int nu, output int nd, output int no,
                          output int ns, output int unl);
    nu = 0; nd = 0; no = 0; ns = 0; unl = 0;
    for (int i = 0; i < len + 6; i++) begin
      @(negedge clk);
      nu  += int'(main_oe && main_up);
      nd  += int'(main_oe && main_dn);
      no  += int'(main_oe);
      ns  += int'(sub_oe);
      unl |= int'(!unlock_n);
      div_e = lead ? (i == 0)   : (i == len);
      ref_e = lead ? (i == len) : (i == 0);
    end
    div_e = 1'b0;
    ref_e = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int nu, nd, no, ns, unl;

    // R10: reset state
    @(negedge clk);
    chk("R10 main_oe in reset", int'(main_oe), 0);
    chk("R10 sub_oe in reset", int'(sub_oe), 0);
    chk("R10 unlock_n in reset", int'(unlock_n), 1);

    // table walk: R1 R2 R4 R6 R7 R8 R9
    for (int k = 0; k < 15; k++) begin
      ulw = VECS[k].ulw; dz = VECS[k].dz; sub = VECS[k].sub;
      dlc = VECS[k].dlc; inh = VECS[k].inh;
      do_reset();
      do_pulse(VECS[k].lead, int'(VECS[k].len), nu, nd, no, ns, unl);
      chk($sformatf("R1 R7 R8 R6 R9 up cycles v%0d", k), nu, int'(VECS[k].e_up));
      chk($sformatf("R1 R7 R8 R6 R9 dn cycles v%0d", k), nd, int'(VECS[k].e_dn));
      chk($sformatf("R1 R9 main_oe cycles v%0d", k), no, int'(VECS[k].e_oe));
      chk($sformatf("R4 R6 sub_oe cycles v%0d", k), ns, int'(VECS[k].e_sub));
      chk($sformatf("R2 unlock seen v%0d", k), unl, int'(VECS[k].e_unl));
    end

    // R2: disabled detection leaves flag open
    ulw = 2'b00; dlc = 1'b0; inh = 1'b0;
    @(negedge clk);
    chk("R2 unlock_oe when off", int'(unlock_oe), 0);
    chk("R2 unlock_n when off", int'(unlock_n), 1);

    // R5 / R3: lock-gated sub pump and hold time
    ulw = 2'b01; dz = 2'b10; sub = 2'b10;
    do_reset();
    do_pulse(1'b1, 7, nu, nd, no, ns, unl);
    chk("R5 main up cycles unlocked", nu, 6);
    chk("R5 sub runs while unlocked", ns, 3);
    chk("R2 unlock at 7 > 4", unl, 1);
    repeat (20) @(negedge clk);
    chk("R3 held without ticks", int'(unlock_n), 0);
    ms = 1'b1;
    @(negedge clk);
    ms = 1'b0;
    @(negedge clk);
    chk("R3 held after first tick", int'(unlock_n), 0);
    ms = 1'b1;
    @(negedge clk);
    ms = 1'b0;
    chk("R3 released after second tick", int'(unlock_n), 1);
    do_pulse(1'b1, 3, nu, nd, no, ns, unl);
    chk("R5 main up cycles locked", nu, 2);
    chk("R5 sub floats when locked", ns, 0);
    chk("R5 no unlock at 3", unl, 0);

    // R6: deadlock clear set and released
    sub = 2'b00;
    dlc = 1'b1;
    @(negedge clk);
    chk("R6 forced low dn", int'(main_oe && main_dn && !main_up), 1);
    dlc = 1'b0;
    @(negedge clk);
    chk("R6 released to float", int'(main_oe), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule